// File: doc/BRIEF.md
# Random Number Generator Command and Status Front End

This block is the register front end of a hardware random number generator. Software reaches it through a simple 32-bit memory-mapped bus with separate read and write strobes. Through that bus it issues commands to run a self-test or to generate a seed, masks the interrupt sources, reads status and error information, and draws random words from a 16-word output FIFO. A single interrupt line reports completed operations and latched errors.

The entropy source and the statistical checker are replaced by stand-ins. A 32-bit Galois LFSR supplies the words. An input pin, `fail_inject`, makes a seed operation fail its statistical check. Self-test and seed each last a fixed, parameterised number of cycles. After a seed succeeds, the FIFO refills itself from the LFSR, one word per cycle, whenever it holds fewer than 16 words.

Top module: `rng_front`

## Requirements
- R1: After reset, control reads 0x00000060 (both interrupt sources masked), status reads 0, the error register reads 0, the FIFO is empty and `irq` is low.
- R2: Registers are selected by `addr[4:2]` (byte offsets: command 0x04, control 0x08, status 0x0C, error 0x10, FIFO 0x14). Reads return data combinationally in the cycle `rd_en` is high. The command register and unmapped offsets always read 0.
- R3: Writing command bit 0 starts a self-test. This clears status bit 4 (test done) and sets it again exactly `ST_CYCLES` clock edges after the write edge. Completion also makes the done source pending.
- R4: Writing command bit 1 starts a seed. This clears status bit 5 (seed done) and sets it again exactly `SEED_CYCLES` edges after the write edge. If the seed succeeds, the FIFO gains one word per edge from the next edge onward until it holds 16.
- R5: Status bits 11:8 give the FIFO fill level, saturated at 15. Status bit 12 is set exactly when the FIFO holds 16 words.
- R6: A read of the FIFO register returns the oldest word and removes it. The words come out in LFSR order: the first equals 0x1ACEB00C, and each next word is `s>>1`, XORed with 0x80200003 when bit 0 of the previous word `s` is 1.
- R7: A read of the empty FIFO returns 0 and leaves the error register at 0.
- R8: If `fail_inject` is high on the completion edge of a seed, the error register becomes 0x00000008, status bit 16 is set, seed done and the done source are still set, and the FIFO is not refilled.
- R9: Command bit 4 clears the pending done source only while the error register is zero.
- R10: Command bit 5 clears the error register, status bit 16 and the pending done source.
- R11: Control bit 5 masks the done source and control bit 6 masks the error source. `irq` is high when any unmasked source is pending, and the error source is pending while the error register is nonzero.
- R12: A start command written while an operation runs is ignored. If bits 0 and 1 are written together, only the self-test starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a FIFO read pops on the edge |
| addr | input | 5 | Byte address, word-aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| fail_inject | input | 1 | Forces the next seed completion to fail its statistical check |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong sequencer count shows up right away as a done flag that sets one status read early or late, and the bench counts every edge from the command write. A wrong FIFO pointer or a wrong LFSR step shows up on the first word read out of order: the bench reads more than one FIFO depth of words while the refill runs, so pointer wrap is covered. A bad clear rule or mask shows on `irq` one cycle after the command or control write. The bench checks every mask combination against both pending sources.

// File: rtl/rng_front_pkg.sv
package rng_front_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_STAT = 3'd3,
        SEL_ERR  = 3'd4,
        SEL_FIFO = 3'd5
    } reg_sel_e;

    // command bit positions
    localparam int unsigned CMD_TEST_BIT   = 0;
    localparam int unsigned CMD_SEED_BIT   = 1;
    localparam int unsigned CMD_CLRINT_BIT = 4;
    localparam int unsigned CMD_CLRERR_BIT = 5;
    // control bit positions
    localparam int unsigned CTL_MDONE_BIT  = 5;
    localparam int unsigned CTL_MERR_BIT   = 6;

    localparam logic [DATA_W-1:0] ERR_STAT_CODE = 32'h0000_0008;

    typedef struct packed {
        logic test;
        logic seed;
        logic clr_int;
        logic clr_err;
    } cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_TEST,
        SEQ_SEED
    } seq_state_e;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.test    = w[CMD_TEST_BIT];
        c.seed    = w[CMD_SEED_BIT];
        c.clr_int = w[CMD_CLRINT_BIT];
        c.clr_err = w[CMD_CLRERR_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s,
                                                    input logic [DATA_W-1:0] taps);
        return {1'b0, s[DATA_W-1:1]} ^ (s[0] ? taps : '0);
    endfunction

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr
    import rng_front_pkg::*;
#(
    parameter logic [DATA_W-1:0] TAPS = 32'h8020_0003,
    parameter logic [DATA_W-1:0] INIT = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)      state_q <= INIT;
        else if (adv) state_q <= lfsr_step(state_q, TAPS);
    end

    assign word = state_q;
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 32,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q;
    logic          do_push, do_pop;

    assign do_pop  = pop && (level_q != '0);
    assign do_push = push && (level_q != LW'(DEPTH));

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign dout  = (level_q == '0) ? '0 : mem[rd_ptr];
    assign level = level_q;
    assign full  = (level_q == LW'(DEPTH));
endmodule

// File: rtl/rng_seq.sv
module rng_seq
    import rng_front_pkg::*;
#(
    parameter int unsigned ST_CYCLES   = 6,
    parameter int unsigned SEED_CYCLES = 10,
    localparam int unsigned MAXC = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES,
    localparam int unsigned CW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_test,
    input  logic start_seed,
    input  logic fail_in,
    output logic busy,
    output logic test_fin,
    output logic seed_ok,
    output logic seed_bad
);
    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (start_test) begin
                state_q <= SEQ_TEST;
                cnt_q   <= CW'(ST_CYCLES - 1);
            end else if (start_seed) begin
                state_q <= SEQ_SEED;
                cnt_q   <= CW'(SEED_CYCLES - 1);
            end
        end else if (last) begin
            state_q <= SEQ_IDLE;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy     = (state_q != SEQ_IDLE);
    assign test_fin = (state_q == SEQ_TEST) && last;
    assign seed_ok  = (state_q == SEQ_SEED) && last && !fail_in;
    assign seed_bad = (state_q == SEQ_SEED) && last && fail_in;
endmodule

// File: rtl/rng_front.sv
module rng_front
    import rng_front_pkg::*;
#(
    parameter int unsigned       ST_CYCLES   = 6,
    parameter int unsigned       SEED_CYCLES = 10,
    parameter int unsigned       FIFO_DEPTH  = 16,
    parameter logic [DATA_W-1:0] LFSR_TAPS   = 32'h8020_0003,
    parameter logic [DATA_W-1:0] LFSR_INIT   = 32'h1ACE_B00C,
    localparam int unsigned      LW          = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fail_inject,
    output logic              irq
);
    reg_sel_e          sel;
    cmd_t              cmd;
    logic              start_test, start_seed;
    logic              seq_busy, test_fin, seed_ok, seed_bad;
    logic              mask_done, mask_err;
    logic              test_done, seed_done, done_pend, seeded;
    logic [DATA_W-1:0] err_q;
    logic              fill_push, fifo_pop, fifo_full;
    logic [DATA_W-1:0] lfsr_word, fifo_word;
    logic [LW-1:0]     fifo_level;
    logic [3:0]        lvl_field;

    assign sel = reg_sel_e'(addr[4:2]);
    assign cmd = (wr_en && sel == SEL_CMD) ? decode_cmd(wdata) : '0;

    assign start_test = cmd.test && !seq_busy;
    assign start_seed = cmd.seed && !cmd.test && !seq_busy;

    rng_seq #(.ST_CYCLES(ST_CYCLES), .SEED_CYCLES(SEED_CYCLES)) u_seq (
        .clk(clk), .rst(rst),
        .start_test(start_test), .start_seed(start_seed), .fail_in(fail_inject),
        .busy(seq_busy), .test_fin(test_fin), .seed_ok(seed_ok), .seed_bad(seed_bad)
    );

    assign fill_push = seeded && !fifo_full;
    assign fifo_pop  = rd_en && (sel == SEL_FIFO);

    rng_lfsr #(.TAPS(LFSR_TAPS), .INIT(LFSR_INIT)) u_lfsr (
        .clk(clk), .rst(rst), .adv(fill_push), .word(lfsr_word)
    );

    rng_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(fill_push), .din(lfsr_word), .pop(fifo_pop),
        .dout(fifo_word), .level(fifo_level), .full(fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_done <= 1'b1;
            mask_err  <= 1'b1;
            test_done <= 1'b0;
            seed_done <= 1'b0;
            done_pend <= 1'b0;
            seeded    <= 1'b0;
            err_q     <= '0;
        end else begin
            if (wr_en && sel == SEL_CTRL) begin
                mask_done <= wdata[CTL_MDONE_BIT];
                mask_err  <= wdata[CTL_MERR_BIT];
            end
            // clears first, so a completion in the same cycle wins
            if (cmd.clr_err) begin
                err_q     <= '0;
                done_pend <= 1'b0;
            end else if (cmd.clr_int && err_q == '0) begin
                done_pend <= 1'b0;
            end
            if (start_test) test_done <= 1'b0;
            if (start_seed) begin
                seed_done <= 1'b0;
                seeded    <= 1'b0;
            end
            if (test_fin) begin
                test_done <= 1'b1;
                done_pend <= 1'b1;
            end
            if (seed_ok || seed_bad) begin
                seed_done <= 1'b1;
                done_pend <= 1'b1;
            end
            if (seed_ok)  seeded <= 1'b1;
            if (seed_bad) err_q  <= ERR_STAT_CODE;
        end
    end

    assign irq = (done_pend && !mask_done) || ((err_q != '0) && !mask_err);

    assign lvl_field = (fifo_level > LW'(15)) ? 4'hF : 4'(fifo_level);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CTRL: begin
                    rdata[CTL_MDONE_BIT] = mask_done;
                    rdata[CTL_MERR_BIT]  = mask_err;
                end
                SEL_STAT: begin
                    rdata[4]    = test_done;
                    rdata[5]    = seed_done;
                    rdata[11:8] = lvl_field;
                    rdata[12]   = fifo_full;
                    rdata[16]   = (err_q != '0);
                end
                SEL_ERR:  rdata = err_q;
                SEL_FIFO: rdata = fifo_word;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rng_front_chk.sv
module rng_front_chk
    import rng_front_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [LW-1:0]     fifo_level,
    input logic              fill_push,
    input logic              done_pend,
    input logic [DATA_W-1:0] err_q,
    input logic              seq_busy
);
    logic cmd_wr, fifo_rd;
    assign cmd_wr  = wr_en && addr[4:2] == 3'd1;
    assign fifo_rd = rd_en && addr[4:2] == 3'd5;

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[4:2] == 3'd1) |-> rdata == '0); // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH)); // R4

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fifo_level == '0) |-> rdata == '0); // R7

    AST_POP_TAKES_ONE: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fifo_level != '0 && !fill_push) |=> fifo_level == $past(fifo_level) - 1'b1); // R6

    AST_CLRINT_HELD_BY_ERR: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[4] && !wdata[5] && err_q != '0 && done_pend) |=> done_pend); // R9

    AST_CLRERR_WIPES: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[5] && !seq_busy) |=> (err_q == '0 && !done_pend)); // R10
endmodule

bind rng_front rng_front_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fifo_level(fifo_level), .fill_push(fill_push),
    .done_pend(done_pend), .err_q(err_q), .seq_busy(seq_busy)
);

// File: tb/rng_front_test.sv
module rng_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int STC  = 6;
    localparam int SDC  = 10;
    localparam logic [31:0] TAPS = 32'h8020_0003;
    localparam logic [31:0] INIT = 32'h1ACE_B00C;
    localparam logic [4:0] A_CMD = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C,
                           A_ERR = 5'h10, A_FIFO = 5'h14, A_NONE = 5'h18;

    logic        clk = 0, rst = 1, wr_en = 0, rd_en = 0, fail_inject = 0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic [31:0] model;

    rng_front #(.ST_CYCLES(STC), .SEED_CYCLES(SDC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .fail_inject(fail_inject), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // each access starts at a negedge and ends at the next negedge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 0;
        @(negedge clk);
    endtask

    // poll status bit until set, returning the number of edges since the command write
    task automatic wait_bit(input int b, output int edges);
        logic [31:0] s;
        edges = -1;
        for (int k = 0; k < 200; k++) begin
            bus_read(A_STAT, s);
            if (s[b]) begin edges = k; break; end
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int e;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_read(A_CTRL, d); check("R1 ctrl", d, 32'h60);
        bus_read(A_STAT, d); check("R1 status", d, 32'h0);
        bus_read(A_ERR, d);  check("R1 error", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        // R2 command and unmapped read zero
        bus_read(A_CMD, d);  check("R2 cmd", d, 32'h0);
        bus_read(A_NONE, d); check("R2 unmapped", d, 32'h0);
        // R7 empty read
        bus_read(A_FIFO, d); check("R7 empty data", d, 32'h0);
        bus_read(A_ERR, d);  check("R7 no error", d, 32'h0);

        // R3 self-test timing, masked irq
        bus_write(A_CMD, 32'h1);
        wait_bit(4, e); check("R3 test edges", e, STC);
        check("R11 done masked", {31'b0, irq}, 32'h0);
        bus_write(A_CTRL, 32'h40);
        check("R11 done unmasked", {31'b0, irq}, 32'h1);
        bus_write(A_CMD, 32'h10);
        check("R9 clr_int no error", {31'b0, irq}, 32'h0);

        // R12 seed during self-test is ignored
        bus_write(A_CMD, 32'h1);
        bus_write(A_CMD, 32'h2);
        wait_bit(4, e); check("R12 test edges", e, STC - 1);
        repeat (SDC + 4) bus_read(A_STAT, d);
        check("R12 seed ignored", d & 32'h1F20, 32'h0);
        // R12 both bits: self-test wins
        bus_write(A_CMD, 32'h3);
        wait_bit(4, e); check("R12 both bits test", e, STC);
        repeat (SDC + 4) bus_read(A_STAT, d);
        check("R12 both bits no seed", d & 32'h1F20, 32'h0);
        bus_write(A_CMD, 32'h10);

        // R8 failing seed
        fail_inject = 1;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CMD, 32'h2);
        wait_bit(5, e); check("R8 seed edges", e, SDC);
        fail_inject = 0;
        bus_read(A_ERR, d); check("R8 error code", d, 32'h8);
        repeat (4) bus_read(A_STAT, d);
        check("R8 status err no fill", d & 32'h11F00, 32'h10000);
        check("R8 irq", {31'b0, irq}, 32'h1);
        // R9 clr_int held while error, seen with error source masked
        bus_write(A_CTRL, 32'h40);
        bus_write(A_CMD, 32'h10);
        check("R9 done held by error", {31'b0, irq}, 32'h1);
        // R11 error source alone
        bus_write(A_CTRL, 32'h20);
        check("R11 error unmasked", {31'b0, irq}, 32'h1);
        bus_write(A_CTRL, 32'h60);
        check("R11 both masked", {31'b0, irq}, 32'h0);
        bus_write(A_CTRL, 32'h20);
        // R10 clear error
        bus_write(A_CMD, 32'h20);
        check("R10 irq after clr_err", {31'b0, irq}, 32'h0);
        bus_read(A_ERR, d); check("R10 error reg", d, 32'h0);
        bus_read(A_STAT, d); check("R10 status err", d & 32'h10000, 32'h0);
        bus_write(A_CTRL, 32'h0);
        check("R10 done cleared", {31'b0, irq}, 32'h0);

        // R4/R5 successful seed and fill
        bus_write(A_CMD, 32'h2);
        wait_bit(5, e); check("R4 seed edges", e, SDC);
        check("R11 seed irq", {31'b0, irq}, 32'h1);
        for (int j = 1; j <= 20; j++) begin
            int lv;
            bus_read(A_STAT, d);
            lv = (j > 16) ? 16 : j;
            check("R5 level field", {28'b0, d[11:8]}, (lv > 15) ? 32'd15 : lv);
            check("R5 full bit", {31'b0, d[12]}, (lv == 16) ? 32'd1 : 32'd0);
        end
        // R6 word order across wrap while refilling
        model = INIT;
        for (int j = 0; j < 24; j++) begin
            bus_read(A_FIFO, d);
            check("R6 fifo word", d, model);
            model = step(model);
        end
        finish_run();
    end
endmodule